// File: doc/BRIEF.md
# Surface copy path selector

This block decides which of four copy engines should move a rectangle of pixels from a source surface to a destination surface. Each side of the transfer is described by its corner coordinates, its width, height and depth, its bytes per pixel, its row pitch and, for the destination, its byte offset and whether it lives in video memory. A pitch of zero marks a swizzled (block-interleaved) layout rather than a linear one. A further input says whether the 3D engine belongs to the newer capability generation.

The engines are tried in a fixed priority. The first one whose eligibility rules all hold is chosen. The choice is registered and appears one clock after the request as a one-hot select with a valid strobe. When no engine can take the transfer, an error flag is raised instead.

Top module: `pathsel_top`

## Requirements
- R1: Outputs `engineSel`, `selValid` and `noEngine` are zero after reset and in every cycle that does not follow a cycle with `reqValid` high. A request sampled at a rising edge produces its result in the outputs right after that edge, for exactly one cycle.
- R2: The select is one-hot, with bit 0 for linear copy, bit 1 for scaled image, bit 2 for 3D blit and bit 3 for fallback. When several engines are eligible, the lowest bit wins.
- R3: A transfer is scaled when the source span (x1 minus x0, or y1 minus y0) differs from the destination span in X or in Y. Linear copy is eligible exactly when both pitches are nonzero and the transfer is not scaled.
- R4: Scaled image needs all of the following: a nonzero source pitch, source width and height of at least 2, the bitwise OR of source width and height not above 1024, both depths at most 1, and a destination offset that is a multiple of 64.
- R5: For scaled image with a zero destination pitch, destination width and height must each be at least 2, and their bitwise OR must not exceed 2048.
- R6: For scaled image with a nonzero destination pitch, the destination must be in video memory and its pitch must be a multiple of 64.
- R7: The 3D blit needs all of the following: the newer-generation flag, a destination offset and pitch that are multiples of 64, a destination depth of at most 1, destination width and height of at least 2, and both bytes-per-pixel values at most 4. It is not eligible when the destination has 1 byte per pixel together with a zero pitch. It does not require the transfer to be unscaled.
- R8: The fallback engine is eligible whenever the transfer is not scaled.
- R9: When a request finds no eligible engine, `noEngine` is 1, `selValid` is 0 and `engineSel` is zero. Otherwise `selValid` is 1 and `noEngine` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request strobe; descriptors are sampled while high |
| newGen | input | 1 | 3D engine belongs to the newer generation |
| srcX0 | input | COORD_W | Source left edge |
| srcX1 | input | COORD_W | Source right edge |
| srcY0 | input | COORD_W | Source top edge |
| srcY1 | input | COORD_W | Source bottom edge |
| srcW | input | DIM_W | Source surface width |
| srcH | input | DIM_W | Source surface height |
| srcD | input | DIM_W | Source surface depth |
| srcCpp | input | CPP_W | Source bytes per pixel |
| srcPitch | input | PITCH_W | Source pitch, zero for swizzled |
| dstX0 | input | COORD_W | Destination left edge |
| dstX1 | input | COORD_W | Destination right edge |
| dstY0 | input | COORD_W | Destination top edge |
| dstY1 | input | COORD_W | Destination bottom edge |
| dstW | input | DIM_W | Destination surface width |
| dstH | input | DIM_W | Destination surface height |
| dstD | input | DIM_W | Destination surface depth |
| dstCpp | input | CPP_W | Destination bytes per pixel |
| dstPitch | input | PITCH_W | Destination pitch, zero for swizzled |
| dstOffset | input | OFF_W | Destination byte offset |
| dstVram | input | 1 | Destination is in video memory |
| engineSel | output | 4 | One-hot engine choice |
| selValid | output | 1 | A choice was made for the previous request |
| noEngine | output | 1 | No engine was eligible for the previous request |

## Verification
Directed descriptors first aim at each engine alone. They then overlap eligibility sets, which separates a wrong priority from a wrong rule. Size limits are probed at 1, 2, 1024, 1025 and 2048, together with pairs such as 1024 by 1000 and 2048 by 2. Those pairs pass a per-dimension test but fail the OR test, so they expose any design that compares width and height one at a time. Alignment, memory domain, generation flag, depth and the 1-byte swizzled destination are each flipped alone to show that they gate only the engine they belong to. A long run of random descriptors from small value sets then exercises the combinations, and a behavioural model judges every cycle.

// File: rtl/pathsel_pkg.sv
package pathsel_pkg;

  localparam int NUM_ENG = 4;

  // Bit order of this struct is the priority order: bit 0 is tried first.
  typedef struct packed {
    logic fallback;
    logic blit3d;
    logic scaledImg;
    logic linear;
  } eligT;

endpackage

// File: rtl/pathsel_datapath.sv
module pathsel_datapath
  import pathsel_pkg::*;
#(
  parameter int COORD_W    = 16,
  parameter int DIM_W      = 16,
  parameter int CPP_W      = 4,
  parameter int PITCH_W    = 16,
  parameter int OFF_W      = 32,
  parameter int ALIGN      = 64,
  parameter int SRC_MAX    = 1024,
  parameter int SWZ_MAX    = 2048,
  parameter int MIN_DIM    = 2,
  parameter int MAX_CPP    = 4
) (
  input  logic               newGen,
  input  logic [COORD_W-1:0] srcX0,
  input  logic [COORD_W-1:0] srcX1,
  input  logic [COORD_W-1:0] srcY0,
  input  logic [COORD_W-1:0] srcY1,
  input  logic [DIM_W-1:0]   srcW,
  input  logic [DIM_W-1:0]   srcH,
  input  logic [DIM_W-1:0]   srcD,
  input  logic [CPP_W-1:0]   srcCpp,
  input  logic [PITCH_W-1:0] srcPitch,
  input  logic [COORD_W-1:0] dstX0,
  input  logic [COORD_W-1:0] dstX1,
  input  logic [COORD_W-1:0] dstY0,
  input  logic [COORD_W-1:0] dstY1,
  input  logic [DIM_W-1:0]   dstW,
  input  logic [DIM_W-1:0]   dstH,
  input  logic [DIM_W-1:0]   dstD,
  input  logic [CPP_W-1:0]   dstCpp,
  input  logic [PITCH_W-1:0] dstPitch,
  input  logic [OFF_W-1:0]   dstOffset,
  input  logic               dstVram,
  output eligT               elig
);

  localparam logic [DIM_W-1:0]   SRC_LIM   = DIM_W'(SRC_MAX);
  localparam logic [DIM_W-1:0]   SWZ_LIM   = DIM_W'(SWZ_MAX);
  localparam logic [DIM_W-1:0]   DIM_FLOOR = DIM_W'(MIN_DIM);
  localparam logic [DIM_W-1:0]   FLAT_D    = DIM_W'(1);
  localparam logic [CPP_W-1:0]   CPP_LIM   = CPP_W'(MAX_CPP);
  localparam logic [CPP_W-1:0]   CPP_ONE   = CPP_W'(1);
  localparam logic [PITCH_W-1:0] P_MASK    = PITCH_W'(ALIGN - 1);
  localparam logic [OFF_W-1:0]   O_MASK    = OFF_W'(ALIGN - 1);

  // span comparison
  logic [COORD_W-1:0] srcSpanX, srcSpanY, dstSpanX, dstSpanY;
  logic               scaled;

  always_comb begin
    srcSpanX = srcX1 - srcX0;
    srcSpanY = srcY1 - srcY0;
    dstSpanX = dstX1 - dstX0;
    dstSpanY = dstY1 - dstY0;
    scaled   = (srcSpanX != dstSpanX) || (srcSpanY != dstSpanY);
  end

  // layout and alignment facts
  logic srcLinear, dstLinear, dstOffAligned, dstPitchAligned;
  logic srcFlat, dstFlat;

  always_comb begin
    srcLinear       = (srcPitch != '0);
    dstLinear       = (dstPitch != '0);
    dstOffAligned   = ((dstOffset & O_MASK) == '0);
    dstPitchAligned = ((dstPitch & P_MASK) == '0);
    srcFlat         = (srcD <= FLAT_D);
    dstFlat         = (dstD <= FLAT_D);
  end

  // size windows; the upper bound tests the OR of both dimensions
  logic srcSizeOk, dstSwzSizeOk, dstMinOk;

  always_comb begin
    srcSizeOk    = ((srcW | srcH) <= SRC_LIM) && (srcW >= DIM_FLOOR) && (srcH >= DIM_FLOOR);
    dstMinOk     = (dstW >= DIM_FLOOR) && (dstH >= DIM_FLOOR);
    dstSwzSizeOk = ((dstW | dstH) <= SWZ_LIM) && dstMinOk;
  end

  // per-engine rules
  logic okLinear, okScaled, okBlit, okFallback;
  logic scaledDstOk;

  always_comb begin
    okLinear    = srcLinear && dstLinear && !scaled;

    if (dstLinear) scaledDstOk = dstVram && dstPitchAligned;
    else           scaledDstOk = dstSwzSizeOk;

    okScaled    = srcLinear && srcSizeOk && srcFlat && dstFlat &&
                  dstOffAligned && scaledDstOk;

    okBlit      = newGen && dstOffAligned && dstPitchAligned && dstFlat &&
                  dstMinOk && (dstCpp <= CPP_LIM) && (srcCpp <= CPP_LIM) &&
                  !((dstCpp == CPP_ONE) && !dstLinear);

    okFallback  = !scaled;
  end

  always_comb begin
    elig.linear    = okLinear;
    elig.scaledImg = okScaled;
    elig.blit3d    = okBlit;
    elig.fallback  = okFallback;
  end

endmodule

// File: rtl/pathsel_ctrl.sv
module pathsel_ctrl
  import pathsel_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  input  eligT               elig,
  output logic [NUM_ENG-1:0] engineSel,
  output logic               selValid,
  output logic               noEngine
);

  logic [NUM_ENG-1:0] eligVec;
  logic [NUM_ENG-1:0] pick;
  logic               anyElig;

  assign eligVec = elig;

  // fixed priority: lowest set bit wins
  always_comb begin
    pick = '0;
    for (int i = NUM_ENG - 1; i >= 0; i--) begin
      if (eligVec[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
    anyElig = |eligVec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      engineSel <= '0;
      selValid  <= 1'b0;
      noEngine  <= 1'b0;
    end else begin
      engineSel <= reqValid ? pick : '0;
      selValid  <= reqValid && anyElig;
      noEngine  <= reqValid && !anyElig;
    end
  end

endmodule

// File: rtl/pathsel_top.sv
module pathsel_top
  import pathsel_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int DIM_W   = 16,
  parameter int CPP_W   = 4,
  parameter int PITCH_W = 16,
  parameter int OFF_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  input  logic               newGen,
  input  logic [COORD_W-1:0] srcX0,
  input  logic [COORD_W-1:0] srcX1,
  input  logic [COORD_W-1:0] srcY0,
  input  logic [COORD_W-1:0] srcY1,
  input  logic [DIM_W-1:0]   srcW,
  input  logic [DIM_W-1:0]   srcH,
  input  logic [DIM_W-1:0]   srcD,
  input  logic [CPP_W-1:0]   srcCpp,
  input  logic [PITCH_W-1:0] srcPitch,
  input  logic [COORD_W-1:0] dstX0,
  input  logic [COORD_W-1:0] dstX1,
  input  logic [COORD_W-1:0] dstY0,
  input  logic [COORD_W-1:0] dstY1,
  input  logic [DIM_W-1:0]   dstW,
  input  logic [DIM_W-1:0]   dstH,
  input  logic [DIM_W-1:0]   dstD,
  input  logic [CPP_W-1:0]   dstCpp,
  input  logic [PITCH_W-1:0] dstPitch,
  input  logic [OFF_W-1:0]   dstOffset,
  input  logic               dstVram,
  output logic [3:0]         engineSel,
  output logic               selValid,
  output logic               noEngine
);

  eligT elig;

  pathsel_datapath #(
    .COORD_W(COORD_W), .DIM_W(DIM_W), .CPP_W(CPP_W),
    .PITCH_W(PITCH_W), .OFF_W(OFF_W)
  ) u_dp (
    .newGen(newGen),
    .srcX0(srcX0), .srcX1(srcX1), .srcY0(srcY0), .srcY1(srcY1),
    .srcW(srcW), .srcH(srcH), .srcD(srcD), .srcCpp(srcCpp), .srcPitch(srcPitch),
    .dstX0(dstX0), .dstX1(dstX1), .dstY0(dstY0), .dstY1(dstY1),
    .dstW(dstW), .dstH(dstH), .dstD(dstD), .dstCpp(dstCpp), .dstPitch(dstPitch),
    .dstOffset(dstOffset), .dstVram(dstVram),
    .elig(elig)
  );

  pathsel_ctrl u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .elig(elig),
    .engineSel(engineSel), .selValid(selValid), .noEngine(noEngine)
  );

endmodule

// File: rtl/pathsel_checker.sv
module pathsel_checker #(
  parameter int COORD_W = 16,
  parameter int PITCH_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               reqValid,
  input logic [COORD_W-1:0] srcX0,
  input logic [COORD_W-1:0] srcX1,
  input logic [COORD_W-1:0] srcY0,
  input logic [COORD_W-1:0] srcY1,
  input logic [COORD_W-1:0] dstX0,
  input logic [COORD_W-1:0] dstX1,
  input logic [COORD_W-1:0] dstY0,
  input logic [COORD_W-1:0] dstY1,
  input logic [PITCH_W-1:0] srcPitch,
  input logic [PITCH_W-1:0] dstPitch,
  input logic [3:0]         engineSel,
  input logic               selValid,
  input logic               noEngine
);

  logic sameSpan;
  assign sameSpan = ((srcX1 - srcX0) == (dstX1 - dstX0)) &&
                    ((srcY1 - srcY0) == (dstY1 - dstY0));

  // R1: nothing appears without a request in the previous cycle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> (engineSel == 4'b0) && !selValid && !noEngine);

  // R1: every request yields exactly one outcome next cycle
  a_r1_answer: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> (selValid != noEngine));

  // R2: select is one-hot when valid
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    selValid |-> $onehot0(engineSel) && (engineSel != 4'b0));

  // R3: unscaled linear-to-linear picks the linear engine
  a_r3_linear_first: assert property (@(posedge clk) disable iff (rst)
    (reqValid && sameSpan && srcPitch != '0 && dstPitch != '0) |=> engineSel == 4'b0001);

  // R8: an unscaled transfer never ends in the error flag
  a_r8_fallback_covers: assert property (@(posedge clk) disable iff (rst)
    (reqValid && sameSpan) |=> !noEngine);

  // R9: error excludes any select
  a_r9_error_alone: assert property (@(posedge clk) disable iff (rst)
    noEngine |-> (engineSel == 4'b0) && !selValid);

endmodule

bind pathsel_top pathsel_checker #(.COORD_W(COORD_W), .PITCH_W(PITCH_W)) chk (.*);

// File: tb/pathsel_top_test.sv
module pathsel_top_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;   // 125 MHz

  logic        reqValid = 1'b0, newGen = 1'b0;
  logic [15:0] sX0 = 0, sX1 = 0, sY0 = 0, sY1 = 0, sW = 0, sH = 0, sD = 0, sPitch = 0;
  logic [15:0] dX0 = 0, dX1 = 0, dY0 = 0, dY1 = 0, dW = 0, dH = 0, dD = 0, dPitch = 0;
  logic [3:0]  sCpp = 0, dCpp = 0;
  logic [31:0] dOff = 0;
  logic        dVram = 1'b0;
  logic [3:0]  engineSel;
  logic        selValid, noEngine;

  pathsel_top uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .newGen(newGen),
    .srcX0(sX0), .srcX1(sX1), .srcY0(sY0), .srcY1(sY1),
    .srcW(sW), .srcH(sH), .srcD(sD), .srcCpp(sCpp), .srcPitch(sPitch),
    .dstX0(dX0), .dstX1(dX1), .dstY0(dY0), .dstY1(dY1),
    .dstW(dW), .dstH(dH), .dstD(dD), .dstCpp(dCpp), .dstPitch(dPitch),
    .dstOffset(dOff), .dstVram(dVram),
    .engineSel(engineSel), .selValid(selValid), .noEngine(noEngine)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural reference: returns engine index 0..3, or 4 when none fits
  function automatic int refPick();
    int spx, spy, dpx, dpy;
    bit isScaled, e0, e1, e2, e3, dstOk;
    spx = (int'(sX1) - int'(sX0)) & 16'hFFFF;
    spy = (int'(sY1) - int'(sY0)) & 16'hFFFF;
    dpx = (int'(dX1) - int'(dX0)) & 16'hFFFF;
    dpy = (int'(dY1) - int'(dY0)) & 16'hFFFF;
    isScaled = (spx != dpx) || (spy != dpy);
    e0 = (sPitch != 0) && (dPitch != 0) && !isScaled;
    if (dPitch == 0)
      dstOk = (int'(dW | dH) <= 2048) && dW >= 2 && dH >= 2;
    else
      dstOk = dVram && (dPitch % 64 == 0);
    e1 = (sPitch != 0) && (int'(sW | sH) <= 1024) && sW >= 2 && sH >= 2 &&
         sD <= 1 && dD <= 1 && (dOff % 64 == 0) && dstOk;
    e2 = newGen && (dOff % 64 == 0) && (dPitch % 64 == 0) && dD <= 1 &&
         dW >= 2 && dH >= 2 && dCpp <= 4 && sCpp <= 4 &&
         !(dCpp == 1 && dPitch == 0);
    e3 = !isScaled;
    if (e0) return 0;
    if (e1) return 1;
    if (e2) return 2;
    if (e3) return 3;
    return 4;
  endfunction

  task automatic compare(input string tag, input logic [3:0] eSel, input logic eVal, input logic eErr);
    checks++;
    if (engineSel !== eSel || selValid !== eVal || noEngine !== eErr) begin
      fails++;
      $display("FAIL %s: got sel=%b val=%b err=%b, expected sel=%b val=%b err=%b",
               tag, engineSel, selValid, noEngine, eSel, eVal, eErr);
    end
  endtask

  // one request cycle followed by the check in the next half period
  task automatic runReq(input string tag);
    int k;
    logic [3:0] eSel;
    @(negedge clk);
    reqValid = 1'b1;
    @(posedge clk);
    k = refPick();
    eSel = (k < 4) ? (4'b0001 << k) : 4'b0000;
    @(negedge clk);
    reqValid = 1'b0;
    compare(tag, eSel, k < 4, k == 4);
  endtask

  task automatic idleCheck(input string tag);
    @(posedge clk);
    @(negedge clk);
    compare(tag, 4'b0000, 1'b0, 1'b0);
  endtask

  // baseline: unscaled 16x16 copy, linear both sides, all rules friendly
  task automatic baseDesc();
    newGen = 1'b0;
    sX0 = 0; sX1 = 16; sY0 = 0; sY1 = 16;
    dX0 = 8; dX1 = 24; dY0 = 4; dY1 = 20;
    sW = 64; sH = 64; sD = 1; sCpp = 4; sPitch = 256;
    dW = 64; dH = 64; dD = 1; dCpp = 4; dPitch = 256;
    dOff = 0; dVram = 1'b1;
  endtask

  // scaled: destination span twice the source span
  task automatic makeScaled();
    dX0 = 0; dX1 = 32; dY0 = 0; dY1 = 32;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare("R1 reset state", 4'b0000, 1'b0, 1'b0);
    idleCheck("R1 idle after reset");

    baseDesc();
    runReq("R2 R3 linear wins over fallback");
    idleCheck("R1 single-cycle result");

    baseDesc(); sPitch = 0;
    runReq("R8 swizzled source unscaled -> fallback");
    baseDesc(); dY1 = 21;
    runReq("R3 Y span differs -> no linear");

    baseDesc(); makeScaled();
    runReq("R4 R6 scaled image, linear vram dst");
    baseDesc(); makeScaled(); dVram = 1'b0;
    runReq("R6 R9 non-vram dst, old gen -> none");
    baseDesc(); makeScaled(); dVram = 1'b0; newGen = 1'b1;
    runReq("R7 blit takes scaled transfer");
    baseDesc(); makeScaled(); dPitch = 288;
    runReq("R6 dst pitch not multiple of 64 -> none");

    // source size boundaries
    baseDesc(); makeScaled(); sW = 1;    runReq("R4 src width 1");
    baseDesc(); makeScaled(); sW = 2;  sH = 2; runReq("R4 src 2x2");
    baseDesc(); makeScaled(); sW = 1024; sH = 1024; runReq("R4 src 1024x1024");
    baseDesc(); makeScaled(); sW = 1025; runReq("R4 src width 1025");
    baseDesc(); makeScaled(); sW = 1024; sH = 1000; runReq("R4 OR of 1024 and 1000");
    baseDesc(); makeScaled(); sH = 2048; runReq("R4 src height 2048");
    baseDesc(); makeScaled(); sD = 2;    runReq("R4 src depth 2");
    baseDesc(); makeScaled(); dOff = 32; runReq("R4 dst offset 32");

    // swizzled destination boundaries
    baseDesc(); makeScaled(); dPitch = 0; dW = 2048; dH = 2048; runReq("R5 swz dst 2048x2048");
    baseDesc(); makeScaled(); dPitch = 0; dW = 2048; dH = 2;    runReq("R5 OR of 2048 and 2");
    baseDesc(); makeScaled(); dPitch = 0; dW = 1;               runReq("R5 swz dst width 1");
    baseDesc(); makeScaled(); dPitch = 0; dW = 1024; dH = 1025; runReq("R5 swz dst 1024x1025");
    baseDesc(); makeScaled(); dPitch = 0; dVram = 1'b0;         runReq("R5 swz dst ignores domain");

    // blit rules, scaled image disabled via zero source pitch
    baseDesc(); makeScaled(); sPitch = 0; newGen = 1'b1; runReq("R7 blit basic");
    baseDesc(); makeScaled(); sPitch = 0;                runReq("R7 R9 old gen");
    baseDesc(); makeScaled(); sPitch = 0; newGen = 1'b1; dPitch = 0; dCpp = 1; runReq("R7 1-byte swizzled");
    baseDesc(); makeScaled(); sPitch = 0; newGen = 1'b1; dPitch = 0; dCpp = 2; runReq("R7 2-byte swizzled");
    baseDesc(); makeScaled(); sPitch = 0; newGen = 1'b1; dCpp = 1; runReq("R7 1-byte linear");
    baseDesc(); makeScaled(); sPitch = 0; newGen = 1'b1; dCpp = 5; runReq("R7 dst cpp 5");
    baseDesc(); makeScaled(); sPitch = 0; newGen = 1'b1; sCpp = 8; runReq("R7 src cpp 8");
    baseDesc(); makeScaled(); sPitch = 0; newGen = 1'b1; dOff = 64; runReq("R7 dst offset 64");
    baseDesc(); makeScaled(); sPitch = 0; newGen = 1'b1; dOff = 96; runReq("R7 dst offset 96");
    baseDesc(); makeScaled(); sPitch = 0; newGen = 1'b1; dD = 2;    runReq("R7 dst depth 2");
    baseDesc(); makeScaled(); sPitch = 0; newGen = 1'b1; dH = 1;    runReq("R7 dst height 1");
    baseDesc(); sPitch = 0; newGen = 1'b1; runReq("R2 blit over fallback unscaled");

    // random sweep over small value sets
    for (int n = 0; n < 400; n++) begin
      int pick;
      newGen = $urandom_range(1, 0);
      sX0 = 16'($urandom_range(40, 0)); sY0 = 16'($urandom_range(40, 0));
      dX0 = 16'($urandom_range(40, 0)); dY0 = 16'($urandom_range(40, 0));
      sX1 = sX0 + 16'($urandom_range(4, 1)); sY1 = sY0 + 16'($urandom_range(4, 1));
      if ($urandom_range(1, 0) == 1) begin
        dX1 = dX0 + (sX1 - sX0); dY1 = dY0 + (sY1 - sY0);
      end else begin
        dX1 = dX0 + 16'($urandom_range(4, 1)); dY1 = dY0 + 16'($urandom_range(4, 1));
      end
      pick = $urandom_range(5, 0);
      sW = (pick == 0) ? 16'd1 : (pick == 1) ? 16'd1025 : (pick == 2) ? 16'd1024 : 16'($urandom_range(64, 2));
      pick = $urandom_range(5, 0);
      sH = (pick == 0) ? 16'd1 : (pick == 1) ? 16'd2 : 16'($urandom_range(64, 2));
      pick = $urandom_range(5, 0);
      dW = (pick == 0) ? 16'd1 : (pick == 1) ? 16'd2048 : (pick == 2) ? 16'd2049 : 16'($urandom_range(64, 2));
      dH = 16'($urandom_range(64, 1));
      sD = 16'($urandom_range(2, 0)); dD = 16'($urandom_range(2, 0));
      sCpp = 4'($urandom_range(5, 1)); dCpp = 4'($urandom_range(5, 1));
      sPitch = ($urandom_range(2, 0) == 0) ? 16'd0 : 16'(64 * $urandom_range(4, 1));
      pick = $urandom_range(3, 0);
      dPitch = (pick == 0) ? 16'd0 : (pick == 1) ? 16'd96 : 16'(64 * $urandom_range(4, 1));
      dOff = ($urandom_range(1, 0) == 1) ? 32'(64 * $urandom_range(50, 0)) : 32'($urandom_range(200, 0));
      dVram = $urandom_range(1, 0);
      runReq("R2 R3 R4 R5 R6 R7 R8 R9 random");
      if ((n % 7) == 0) idleCheck("R1 random idle gap");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got no completion, expected finish before timeout");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule